// File: doc/BRIEF.md
# Multi-Line Serial RAM Transaction Sequencer

This block runs one complete access to an external serial RAM over a pad group of eight data lines, an active-low chip select, a serial clock and a strobe pad. A single start pulse launches the transaction. The block then walks through a fixed sequence of phases. First comes an 8-bit command, then the address, then an optional 8-bit mode value, then a programmable run of dummy cycles, and last a data phase that sends or receives a given number of bytes. One serial clock cycle equals one cycle of `clk`. The `sclkRun` output tells the pad logic whether the serial clock toggles in the current cycle.

The command, address, transmit-data and receive-data phases each pick their own lane count of 1, 2, 4 or 8 through a 3-bit enable group. The mode phase uses the lane count of the address phase. Options chosen separately for reads and writes decide whether the controller drives the data pads, and for writes the strobe pad, during dummy cycles. Two force bits hold the input enables of the data pads or of the strobe pad high. A 2-bit clock mode sets how many extra clock cycles run after chip select rises, or keeps the clock running at all times.

All transaction settings are captured on the cycle that accepts the start pulse. Write bytes are taken from `wrByte` one at a time. Received bytes appear on `rdByte` with a one-cycle `rdValid` pulse.

Top module: `xram_seq`

## Requirements
- R1: `start` is accepted only when the block is idle. If it is accepted at clock edge E0, then `csN` is low in cycles 1..A after E0 and high otherwise, where A is the sum of all phase lengths. A `start` that arrives during a transaction or during its done cycle is ignored.
- R2: The phases run in a fixed order with fixed lengths. Command is 8 bits. Address is ADDR_W bits. Mode is 8 bits and is present only when `modeEn` is set. Dummy lasts `dummyCycles` cycles. Data is 8 bits per byte. Each phase lasts its bit count divided by its lane count. Mode uses the address lane count.
- R3: Each lane-enable group has this encoding: bit 0 selects 2 lanes, bit 1 selects 4 lanes and bit 2 selects 8 lanes. When several bits are set, the widest lane count wins. When no bit is set, the phase uses one lane. During transmit cycles, `padOe` equals the mask of the lanes in use, and only those lanes.
- R4: Data leaves most-significant bit first. In each cycle the group of L bits sits on pads L-1..0, and the higher pad carries the more significant bit. Single-lane transmit uses pad 0.
- R5: In cycles outside the transmit phases and outside dummy driving, `padOe` is zero. This holds in particular for every receive-data cycle.
- R6: During the dummy cycles of a read, `padOe` is 8'hFF and `padOut` is zero if `rdDummyDrive` is set. Otherwise `padOe` is zero.
- R7: During the dummy cycles of a write, `wrDummyDrive` makes `padOe` 8'hFF with `padOut` zero, and `wrDummyStrobe` asserts `strobeOe`, which drives the strobe pad low. `strobeOe` is low in every other cycle.
- R8: When `dataIeForce` is set, `padIe` is 8'hFF. Otherwise `padIe` is nonzero only in receive-data cycles, where it equals the receiving lane mask; single-lane receive uses pad 1 (8'h02). When `strobeIeForce` is set, `strobeIe` is 1. Otherwise `strobeIe` is high only in receive-data cycles.
- R9: `sclkRun` is high whenever `csN` is low. After `csN` rises, `sclkRun` stays high for 0, 1 or 2 more cycles for clock modes 0, 1 and 2. In mode 3 it is always high.
- R10: `done` is a single-cycle pulse in cycle A+T+1, where T is the number of run-on cycles. In that cycle `csN` is high.
- R11: Byte b of a write is sampled from `wrByte` at the edge that starts its first data cycle. `byteTake` is high during that first cycle, and at no other time.
- R12: In a read, `rdValid` pulses for one cycle in the cycle after the last data cycle of each byte, with the assembled byte on `rdByte`. Single-lane receive samples pad 1. Multi-lane receive samples pads L-1..0. All other pads are ignored.
- R13: A `dummyCycles` of zero removes the dummy phase, and a `byteCnt` of zero removes the data phase. Both phase lengths shrink A accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one serial clock cycle per period |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| isWrite | input | 1 | 1 selects a write data phase, 0 a read |
| cmdCode | input | 8 | Command byte |
| addr | input | ADDR_W | Target address |
| modeEn | input | 1 | Insert the 8-bit mode phase after the address |
| modeVal | input | 8 | Value sent in the mode phase |
| dummyCycles | input | DUM_W | Number of dummy cycles |
| byteCnt | input | CNT_W | Number of data bytes |
| cmdLineEn | input | 3 | Lane enables for the command phase |
| addrLineEn | input | 3 | Lane enables for the address and mode phases |
| txLineEn | input | 3 | Lane enables for write data |
| rxLineEn | input | 3 | Lane enables for read data |
| clkMode | input | 2 | Clock run-on setting |
| rdDummyDrive | input | 1 | Drive data pads low during read dummy cycles |
| wrDummyDrive | input | 1 | Drive data pads low during write dummy cycles |
| wrDummyStrobe | input | 1 | Drive the strobe pad low during write dummy cycles |
| dataIeForce | input | 1 | Hold all data-pad input enables high |
| strobeIeForce | input | 1 | Hold the strobe-pad input enable high |
| wrByte | input | 8 | Next write byte |
| byteTake | output | 1 | A write byte was just taken |
| padIn | input | 8 | Data pad input levels |
| rdByte | output | 8 | Last received byte |
| rdValid | output | 1 | rdByte updated this cycle |
| padOut | output | 8 | Data pad output levels |
| padOe | output | 8 | Data pad output enables |
| padIe | output | 8 | Data pad input enables |
| strobeOe | output | 1 | Strobe pad output enable, driven low |
| strobeIe | output | 1 | Strobe pad input enable |
| csN | output | 1 | Chip select, active low |
| sclkRun | output | 1 | Serial clock toggles this cycle |
| done | output | 1 | Transaction finished |

## Verification
Some rules are checked on every cycle by the assertions. The serial clock must run whenever chip select is low. Mode 0 must leave no clock outside a transaction. The done pulse must last exactly one cycle and fall while chip select is high, with no restart right after it. Write handshakes may occur only in writes and received-byte strobes only in reads. The strobe pad may be driven only inside a write. When input enables are not forced, output enables must stay clear while receiving.

Other properties need the bench's arithmetic timeline. These are the exact phase lengths, the lane grouping and bit order, the widest-wins priority, the dummy-cycle driving, the run-on length and done timing, and the assembled read bytes. The bench sweeps every lane width for the command, address and data phases in both directions.

// File: rtl/xram_pkg.sv
package xram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_MODE, PH_DUMMY, PH_DATA, PH_TAIL, PH_DONE
  } phase_e;

  typedef struct packed {
    logic       loadCmd;
    logic       loadAddr;
    logic       loadMode;
    logic       loadData;
    logic       shift;
    logic       capture;
    logic       byteEnd;
    logic [1:0] laneLg;
  } strobe_t;

  // widest enabled lane group wins; none set means one lane
  function automatic logic [1:0] laneLog(input logic [2:0] en);
    if (en[2])      return 2'd3;
    else if (en[1]) return 2'd2;
    else if (en[0]) return 2'd1;
    else            return 2'd0;
  endfunction

  function automatic logic [3:0] laneCount(input logic [1:0] lg);
    return 4'd1 << lg;
  endfunction

  function automatic logic [7:0] laneMask(input logic [1:0] lg);
    case (lg)
      2'd0:    return 8'h01;
      2'd1:    return 8'h03;
      2'd2:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/xram_ctrl.sv
module xram_ctrl
  import xram_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 8,
  parameter int DUM_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isWriteQ,
  input  logic             modeEnQ,
  input  logic [2:0]       cmdLineEnQ,
  input  logic [2:0]       addrLineEnQ,
  input  logic [2:0]       txLineEnQ,
  input  logic [2:0]       rxLineEnQ,
  input  logic [1:0]       clkModeQ,
  input  logic [CNT_W-1:0] byteCntQ,
  input  logic [DUM_W-1:0] dummyQ,
  output phase_e           phase,
  output strobe_t          stb,
  output logic             idle
);

  localparam int AW_LG = $clog2(ADDR_W);
  localparam int CYC_W = ((AW_LG > DUM_W) ? AW_LG : DUM_W) + 1;

  logic [CYC_W-1:0] cycCnt;
  logic [CYC_W-1:0] lastIdx;
  logic [CNT_W-1:0] byteLeft;
  logic [1:0]       cmdLg, addrLg, dataLg, runOn;
  logic             phaseEnd, lastByte;
  phase_e           afterAddr, afterMode, afterDummy, afterData, nxtPhase;

  assign cmdLg  = laneLog(cmdLineEnQ);
  assign addrLg = laneLog(addrLineEnQ);
  assign dataLg = isWriteQ ? laneLog(txLineEnQ) : laneLog(rxLineEnQ);
  assign runOn  = (clkModeQ == 2'd1 || clkModeQ == 2'd2) ? clkModeQ : 2'd0;

  assign afterData  = (runOn != 2'd0) ? PH_TAIL : PH_DONE;
  assign afterDummy = (byteCntQ != '0) ? PH_DATA : afterData;
  assign afterMode  = (dummyQ != '0) ? PH_DUMMY : afterDummy;
  assign afterAddr  = modeEnQ ? PH_MODE : afterMode;

  always_comb begin
    case (phase)
      PH_CMD:   lastIdx = CYC_W'((8 >> cmdLg) - 1);
      PH_ADDR:  lastIdx = CYC_W'((ADDR_W >> addrLg) - 1);
      PH_MODE:  lastIdx = CYC_W'((8 >> addrLg) - 1);
      PH_DUMMY: lastIdx = CYC_W'(dummyQ) - CYC_W'(1);
      PH_DATA:  lastIdx = CYC_W'((8 >> dataLg) - 1);
      PH_TAIL:  lastIdx = CYC_W'(runOn) - CYC_W'(1);
      default:  lastIdx = '0;
    endcase
  end

  assign phaseEnd = (cycCnt == lastIdx);
  assign lastByte = (byteLeft == CNT_W'(1));

  always_comb begin
    nxtPhase = phase;
    if (phase == PH_IDLE) begin
      if (start) nxtPhase = PH_CMD;
    end else if (phase == PH_DONE) begin
      nxtPhase = PH_IDLE;
    end else if (phaseEnd) begin
      case (phase)
        PH_CMD:   nxtPhase = PH_ADDR;
        PH_ADDR:  nxtPhase = afterAddr;
        PH_MODE:  nxtPhase = afterMode;
        PH_DUMMY: nxtPhase = afterDummy;
        PH_DATA:  nxtPhase = lastByte ? afterData : PH_DATA;
        default:  nxtPhase = PH_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cycCnt   <= '0;
      byteLeft <= '0;
    end else begin
      phase <= nxtPhase;
      if (phase == PH_IDLE || phaseEnd || nxtPhase != phase) cycCnt <= '0;
      else                                                 cycCnt <= cycCnt + CYC_W'(1);
      if (nxtPhase == PH_DATA && phase != PH_DATA)  byteLeft <= byteCntQ;
      else if (phase == PH_DATA && phaseEnd)        byteLeft <= byteLeft - CNT_W'(1);
    end
  end

  always_comb begin
    stb.loadCmd  = (phase == PH_IDLE) && start;
    stb.loadAddr = (phase == PH_CMD) && phaseEnd;
    stb.loadMode = (nxtPhase == PH_MODE) && (phase != PH_MODE);
    stb.loadData = isWriteQ && (nxtPhase == PH_DATA) &&
                   ((phase != PH_DATA) || phaseEnd);
    stb.shift    = (phase == PH_CMD) || (phase == PH_ADDR) ||
                   (phase == PH_MODE) || (phase == PH_DATA);
    stb.capture  = (phase == PH_DATA) && !isWriteQ;
    stb.byteEnd  = (phase == PH_DATA) && phaseEnd;
    case (phase)
      PH_CMD:           stb.laneLg = cmdLg;
      PH_ADDR, PH_MODE: stb.laneLg = addrLg;
      PH_DATA:          stb.laneLg = dataLg;
      default:          stb.laneLg = 2'd0;
    endcase
  end

  assign idle = (phase == PH_IDLE);

endmodule

// File: rtl/xram_dpath.sv
module xram_dpath
  import xram_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  phase_e            phase,
  input  logic              isWriteQ,
  input  logic              rdDummyDriveQ,
  input  logic              wrDummyDriveQ,
  input  logic              wrDummyStrobeQ,
  input  logic              dataIeForce,
  input  logic              strobeIeForce,
  input  logic [7:0]        cmdQ,
  input  logic [ADDR_W-1:0] addrQ,
  input  logic [7:0]        modeValQ,
  input  logic [7:0]        wrByte,
  input  logic [7:0]        padIn,
  output logic [7:0]        padOut,
  output logic [7:0]        padOe,
  output logic [7:0]        padIe,
  output logic              strobeOe,
  output logic              strobeIe,
  output logic [7:0]        rdByte,
  output logic              rdValid,
  output logic              byteTake
);

  localparam int TOP_SH = ADDR_W - 8;

  logic [ADDR_W-1:0] shiftReg;
  logic [7:0]        rxReg, rxNext, inBits, top8, txGrp, mask;
  logic [3:0]        lanes;
  logic              txPhase, rxPhase, dummyDrive;

  assign lanes   = laneCount(stb.laneLg);
  assign mask    = laneMask(stb.laneLg);
  assign top8    = shiftReg[ADDR_W-1 -: 8];
  assign txGrp   = top8 >> (4'd8 - lanes);

  assign txPhase = (phase == PH_CMD) || (phase == PH_ADDR) || (phase == PH_MODE) ||
                   ((phase == PH_DATA) && isWriteQ);
  assign rxPhase = (phase == PH_DATA) && !isWriteQ;
  assign dummyDrive = (phase == PH_DUMMY) &&
                      (isWriteQ ? wrDummyDriveQ : rdDummyDriveQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.loadCmd) begin
      shiftReg <= ADDR_W'(cmdQ) << TOP_SH;
    end else if (stb.loadAddr) begin
      shiftReg <= addrQ;
    end else if (stb.loadMode) begin
      shiftReg <= ADDR_W'(modeValQ) << TOP_SH;
    end else if (stb.loadData) begin
      shiftReg <= ADDR_W'(wrByte) << TOP_SH;
    end else if (stb.shift) begin
      shiftReg <= shiftReg << lanes;
    end
  end

  // note: cmdQ is captured at the same edge as loadCmd; the top routes the
  // live command input here so the first group is correct
  assign inBits = (stb.laneLg == 2'd0) ? {7'b0, padIn[1]} : (padIn & mask);
  assign rxNext = (rxReg << lanes) | inBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg    <= '0;
      rdByte   <= '0;
      rdValid  <= 1'b0;
      byteTake <= 1'b0;
    end else begin
      byteTake <= stb.loadData;
      rdValid  <= stb.capture && stb.byteEnd;
      if (stb.capture) rxReg <= rxNext;
      if (stb.capture && stb.byteEnd) rdByte <= rxNext;
    end
  end

  always_comb begin
    padOut = 8'h00;
    padOe  = 8'h00;
    if (txPhase) begin
      padOut = txGrp;
      padOe  = mask;
    end else if (dummyDrive) begin
      padOe  = 8'hFF;
    end
  end

  always_comb begin
    if (dataIeForce)  padIe = 8'hFF;
    else if (rxPhase) padIe = (stb.laneLg == 2'd0) ? 8'h02 : mask;
    else              padIe = 8'h00;
  end

  assign strobeIe = strobeIeForce || rxPhase;
  assign strobeOe = (phase == PH_DUMMY) && isWriteQ && wrDummyStrobeQ;

endmodule

// File: rtl/xram_seq.sv
module xram_seq
  import xram_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 8,
  parameter int DUM_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isWrite,
  input  logic [7:0]        cmdCode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              modeEn,
  input  logic [7:0]        modeVal,
  input  logic [DUM_W-1:0]  dummyCycles,
  input  logic [CNT_W-1:0]  byteCnt,
  input  logic [2:0]        cmdLineEn,
  input  logic [2:0]        addrLineEn,
  input  logic [2:0]        txLineEn,
  input  logic [2:0]        rxLineEn,
  input  logic [1:0]        clkMode,
  input  logic              rdDummyDrive,
  input  logic              wrDummyDrive,
  input  logic              wrDummyStrobe,
  input  logic              dataIeForce,
  input  logic              strobeIeForce,
  input  logic [7:0]        wrByte,
  output logic              byteTake,
  input  logic [7:0]        padIn,
  output logic [7:0]        rdByte,
  output logic              rdValid,
  output logic [7:0]        padOut,
  output logic [7:0]        padOe,
  output logic [7:0]        padIe,
  output logic              strobeOe,
  output logic              strobeIe,
  output logic              csN,
  output logic              sclkRun,
  output logic              done
);

  phase_e            phase;
  strobe_t           stb;
  logic              idle, accept, active;
  logic              isWriteQ, modeEnQ, rdDummyDriveQ, wrDummyDriveQ, wrDummyStrobeQ;
  logic [2:0]        cmdLineEnQ, addrLineEnQ, txLineEnQ, rxLineEnQ;
  logic [1:0]        clkModeQ;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        modeValQ;
  logic [CNT_W-1:0]  byteCntQ;
  logic [DUM_W-1:0]  dummyQ;

  assign accept = start && idle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isWriteQ       <= 1'b0;
      modeEnQ        <= 1'b0;
      rdDummyDriveQ  <= 1'b0;
      wrDummyDriveQ  <= 1'b0;
      wrDummyStrobeQ <= 1'b0;
      cmdLineEnQ     <= '0;
      addrLineEnQ    <= '0;
      txLineEnQ      <= '0;
      rxLineEnQ      <= '0;
      clkModeQ       <= '0;
      addrQ          <= '0;
      modeValQ       <= '0;
      byteCntQ       <= '0;
      dummyQ         <= '0;
    end else if (accept) begin
      isWriteQ       <= isWrite;
      modeEnQ        <= modeEn;
      rdDummyDriveQ  <= rdDummyDrive;
      wrDummyDriveQ  <= wrDummyDrive;
      wrDummyStrobeQ <= wrDummyStrobe;
      cmdLineEnQ     <= cmdLineEn;
      addrLineEnQ    <= addrLineEn;
      txLineEnQ      <= txLineEn;
      rxLineEnQ      <= rxLineEn;
      clkModeQ       <= clkMode;
      addrQ          <= addr;
      modeValQ       <= modeVal;
      byteCntQ       <= byteCnt;
      dummyQ         <= dummyCycles;
    end
  end

  xram_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DUM_W(DUM_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .isWriteQ    (isWriteQ),
    .modeEnQ     (modeEnQ),
    .cmdLineEnQ  (cmdLineEnQ),
    .addrLineEnQ (addrLineEnQ),
    .txLineEnQ   (txLineEnQ),
    .rxLineEnQ   (rxLineEnQ),
    .clkModeQ    (clkModeQ),
    .byteCntQ    (byteCntQ),
    .dummyQ      (dummyQ),
    .phase       (phase),
    .stb         (stb),
    .idle        (idle)
  );

  // the command byte is loaded at the accepting edge, so it comes from the port
  xram_dpath #(
    .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .phase          (phase),
    .isWriteQ       (isWriteQ),
    .rdDummyDriveQ  (rdDummyDriveQ),
    .wrDummyDriveQ  (wrDummyDriveQ),
    .wrDummyStrobeQ (wrDummyStrobeQ),
    .dataIeForce    (dataIeForce),
    .strobeIeForce  (strobeIeForce),
    .cmdQ           (cmdCode),
    .addrQ          (addrQ),
    .modeValQ       (modeValQ),
    .wrByte         (wrByte),
    .padIn          (padIn),
    .padOut         (padOut),
    .padOe          (padOe),
    .padIe          (padIe),
    .strobeOe       (strobeOe),
    .strobeIe       (strobeIe),
    .rdByte         (rdByte),
    .rdValid        (rdValid),
    .byteTake       (byteTake)
  );

  assign active  = (phase == PH_CMD) || (phase == PH_ADDR) || (phase == PH_MODE) ||
                   (phase == PH_DUMMY) || (phase == PH_DATA);
  assign csN     = !active;
  assign sclkRun = (clkMode == 2'd3) || active || (phase == PH_TAIL);
  assign done    = (phase == PH_DONE);

endmodule

// File: rtl/xram_seq_chk.sv
module xram_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sclkRun,
  input logic [1:0] clkMode,
  input logic [1:0] clkModeQ,
  input logic       done,
  input logic [7:0] padIe,
  input logic [7:0] padOe,
  input logic       dataIeForce,
  input logic       byteTake,
  input logic       isWriteQ,
  input logic       rdValid,
  input logic       strobeOe
);

  p_clk_with_cs_r9: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> sclkRun);

  p_clk_off_mode0_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csN && clkMode == 2'd0 && clkModeQ == 2'd0) |-> !sclkRun);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_cs_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> csN);

  p_no_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> csN);

  p_rx_no_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !dataIeForce && padIe != 8'h00) |-> (padOe == 8'h00));

  p_take_in_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    byteTake |-> (!csN && isWriteQ));

  p_valid_in_read_r12: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !isWriteQ);

  p_strobe_in_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobeOe |-> (!csN && isWriteQ));

endmodule

bind xram_seq xram_seq_chk u_chk (.*);

// File: tb/xram_seq_tb.sv
module xram_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 8;
  localparam int DUM_W  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              isWrite = 1'b0;
  logic [7:0]        cmdCode = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic              modeEn = 1'b0;
  logic [7:0]        modeVal = '0;
  logic [DUM_W-1:0]  dummyCycles = '0;
  logic [CNT_W-1:0]  byteCnt = '0;
  logic [2:0]        cmdLineEn = '0, addrLineEn = '0, txLineEn = '0, rxLineEn = '0;
  logic [1:0]        clkMode = '0;
  logic              rdDummyDrive = 1'b0, wrDummyDrive = 1'b0, wrDummyStrobe = 1'b0;
  logic              dataIeForce = 1'b0, strobeIeForce = 1'b0;
  logic [7:0]        wrByte = '0;
  logic [7:0]        padIn = '0;
  logic              byteTake, rdValid, strobeOe, strobeIe, csN, sclkRun, done;
  logic [7:0]        rdByte, padOut, padOe, padIe;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xram_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DUM_W(DUM_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite), .cmdCode(cmdCode),
    .addr(addr), .modeEn(modeEn), .modeVal(modeVal), .dummyCycles(dummyCycles),
    .byteCnt(byteCnt), .cmdLineEn(cmdLineEn), .addrLineEn(addrLineEn),
    .txLineEn(txLineEn), .rxLineEn(rxLineEn), .clkMode(clkMode),
    .rdDummyDrive(rdDummyDrive), .wrDummyDrive(wrDummyDrive),
    .wrDummyStrobe(wrDummyStrobe), .dataIeForce(dataIeForce),
    .strobeIeForce(strobeIeForce), .wrByte(wrByte), .byteTake(byteTake),
    .padIn(padIn), .rdByte(rdByte), .rdValid(rdValid), .padOut(padOut),
    .padOe(padOe), .padIe(padIe), .strobeOe(strobeOe), .strobeIe(strobeIe),
    .csN(csN), .sclkRun(sclkRun), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lns(input logic [2:0] en);
    if (en[2]) return 8;
    if (en[1]) return 4;
    if (en[0]) return 2;
    return 1;
  endfunction

  function automatic logic [2:0] enc(input int w, input int n);
    case (w)
      0: return 3'b000;
      1: return 3'b001;
      2: return (n % 2 == 1) ? 3'b010 : 3'b011;
      default: return (n % 2 == 1) ? 3'b100 : 3'b111;
    endcase
  endfunction

  function automatic logic [7:0] wrData(input int b);
    return 8'(8'h3C + b * 29);
  endfunction

  function automatic logic [7:0] rdData(input int b);
    return 8'(8'hA5 ^ (b * 37));
  endfunction

  function automatic logic [7:0] grpOf(input logic [31:0] val, input int nb,
                                        input int lanes, input int j);
    return 8'((val >> (nb - (j + 1) * lanes)) & ((1 << lanes) - 1));
  endfunction

  function automatic logic [7:0] maskOf(input int lanes);
    return 8'((1 << lanes) - 1);
  endfunction

  task automatic runTxn(input int cw, input int aw, input int dw, input int rw, input int n);
    int lc, la, ld, tC, tA, tM, tD, tX, bC, bA, bM, bD, bX, aLen, tLen, cpb, wrIdx;
    logic [7:0] expOut, expOe, expIe, expByte, junk, grp;
    logic expSIe, expSOe, expTake, expValid;
    string oeTag, csTag;
    @(negedge clk);
    isWrite       = (rw == 1);
    cmdLineEn     = enc(cw, n);
    addrLineEn    = enc(aw, n + 1);
    txLineEn      = enc(dw, n);
    rxLineEn      = enc(dw, n + 1);
    cmdCode       = 8'(8'hA0 + n * 17);
    addr          = ADDR_W'(24'h5A3C96 ^ (n * 32'h01F3D1));
    modeEn        = ((cw + aw) % 2 == 1);
    modeVal       = 8'(8'h69 + n * 7);
    dummyCycles   = DUM_W'((aw + dw + n) % 3);
    byteCnt       = CNT_W'((cw + dw + rw) % 4);
    clkMode       = 2'((cw + aw + dw + rw) % 4);
    rdDummyDrive  = (aw % 2 == 1);
    wrDummyDrive  = (dw % 2 == 1);
    wrDummyStrobe = (cw % 2 == 1);
    dataIeForce   = (aw + dw == 3);
    strobeIeForce = (cw == 2);
    wrIdx         = 0;
    wrByte        = wrData(0);
    lc = lns(cmdLineEn);
    la = lns(addrLineEn);
    ld = rw ? lns(txLineEn) : lns(rxLineEn);
    cpb = 8 / ld;
    tC = 8 / lc;
    tA = ADDR_W / la;
    tM = modeEn ? 8 / la : 0;
    tD = int'(dummyCycles);
    tX = int'(byteCnt) * cpb;
    bC = tC; bA = bC + tA; bM = bA + tM; bD = bM + tD; bX = bD + tX;
    aLen = bX;
    tLen = (clkMode == 2'd1) ? 1 : (clkMode == 2'd2) ? 2 : 0;
    csTag = (tD == 0 || tX == 0) ? "R13" : "R1";
    start = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= aLen + tLen + 2; k++) begin
      int idx;
      @(negedge clk);
      idx = k - 1;
      start = (k == 2) || (k == aLen + tLen + 1);
      junk = 8'(idx * 53 + 11);
      expOut = 8'h00; expOe = 8'h00; expTake = 1'b0; expSOe = 1'b0;
      expIe = dataIeForce ? 8'hFF : 8'h00;
      expSIe = strobeIeForce;
      oeTag = "R5";
      padIn = junk;
      if (idx < bC) begin
        expOut = grpOf(32'(cmdCode), 8, lc, idx); expOe = maskOf(lc); oeTag = "R3";
        chk("R4 cmd lanes", 32'(padOut), 32'(expOut));
      end else if (idx < bA) begin
        expOut = grpOf(32'(addr), ADDR_W, la, idx - bC); expOe = maskOf(la); oeTag = "R3";
        chk("R2 addr data", 32'(padOut), 32'(expOut));
      end else if (idx < bM) begin
        expOut = grpOf(32'(modeVal), 8, la, idx - bA); expOe = maskOf(la); oeTag = "R3";
        chk("R2 mode data", 32'(padOut), 32'(expOut));
      end else if (idx < bD) begin
        if (rw == 1) begin
          oeTag = "R7";
          if (wrDummyDrive) expOe = 8'hFF;
          expSOe = wrDummyStrobe;
        end else begin
          oeTag = "R6";
          if (rdDummyDrive) expOe = 8'hFF;
        end
        chk("R6 dummy level", 32'(padOut), 32'h0);
      end else if (idx < bX) begin
        int j, b, jj;
        j = idx - bD; b = j / cpb; jj = j % cpb;
        if (rw == 1) begin
          expOut = grpOf(32'(wrData(b)), 8, ld, jj); expOe = maskOf(ld); oeTag = "R3";
          expTake = (jj == 0);
          chk("R11 write data", 32'(padOut), 32'(expOut));
        end else begin
          grp = grpOf(32'(rdData(b)), 8, ld, jj);
          if (!dataIeForce) expIe = (ld == 1) ? 8'h02 : maskOf(ld);
          expSIe = 1'b1;
          if (ld == 1) padIn = (junk & 8'hFD) | 8'(grp << 1);
          else         padIn = (junk & ~maskOf(ld)) | grp;
        end
      end
      expValid = 1'b0; expByte = 8'h00;
      if (rw == 0 && idx - 1 >= bD && idx - 1 < bX && ((idx - bD) % cpb == 0)) begin
        expValid = 1'b1; expByte = rdData((idx - 1 - bD) / cpb);
      end
      chk(csTag, 32'(csN), 32'(k > aLen));
      chk("R9 sclkRun", 32'(sclkRun), 32'((k <= aLen + tLen) || clkMode == 2'd3));
      chk("R10 done", 32'(done), 32'(k == aLen + tLen + 1));
      chk(oeTag, 32'(padOe), 32'(expOe));
      chk("R8 padIe", 32'(padIe), 32'(expIe));
      chk("R8 strobeIe", 32'(strobeIe), 32'(expSIe));
      chk("R7 strobeOe", 32'(strobeOe), 32'(expSOe));
      chk("R11 byteTake", 32'(byteTake), 32'(expTake));
      chk("R12 rdValid", 32'(rdValid), 32'(expValid));
      if (expValid) chk("R12 rdByte", 32'(rdByte), 32'(expByte));
      if (byteTake) begin
        wrIdx++;
        wrByte = wrData(wrIdx);
      end
    end
    start = 1'b0;
    padIn = 8'h00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset csN", 32'(csN), 32'h1);
    chk("R9 reset sclkRun", 32'(sclkRun), 32'h0);
    chk("R10 reset done", 32'(done), 32'h0);
    chk("R5 reset padOe", 32'(padOe), 32'h0);
    chk("R12 reset rdValid", 32'(rdValid), 32'h0);
    for (int n = 0; n < 128; n++) begin
      runTxn(n % 4, (n / 4) % 4, (n / 16) % 4, (n / 64) % 2, n);
      repeat (2) @(negedge clk);
      chk("R1 idle csN", 32'(csN), 32'h1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule